// File: doc/BRIEF.md
# Prescaled Reloadable Countdown Timer

This block is a 20-bit down-counter that runs in the domain of a 13.56 MHz carrier clock. It has two counting modes. In the first it steps on every clock edge. In the second it steps only on tick pulses from a power-of-two divider, and a 3-bit code selects the division ratio, from 2 up to 256. The divider is a free-running counter that produces a one-cycle enable. No clock is ever derived from it.

Software stores a start value through a small write port. That value is copied into the counter when the run control goes from low to high. When the count reaches zero, the behaviour depends on a mode bit: the block either stays at zero (single shot) or reloads the start value and counts down again (repeating). Each expiry produces a one-cycle strobe that an interrupt controller can pick up.

Top module: `carrier_countdown_timer`

## Requirements
- R1: A write with `cfg_wr_en` high stores `cfg_wr_data[19:0]` as the start value and ignores bits 31:20. `start_rd_o` returns the start value in bits 19:0 and zero in bits 31:20. The start value resets to 0.
- R2: While `rst_n` is low at a clock edge, `count_o` becomes 0, `expire_o` becomes 0 and the start value becomes 0.
- R3: At the first edge where `run_en` is high after being low at the previous edge, `count_o` takes the start value held before that edge. A write in that same cycle does not affect this load.
- R4: With `prescale_on` low and `run_en` high, a nonzero count drops by exactly one at every edge after the load edge.
- R5: With `prescale_on` high, the count steps once per 2^(code+1) clocks. Code 000 divides by 2, 001 by 4, and so on up to 111, which divides by 256. The divider restarts at the load edge, and the first step comes 2^(code+1)-1 edges after that edge.
- R6: While `run_en` is low, `count_o` holds its value and the divider is held at its start phase.
- R7: With `reload_on` low, a step from 1 leaves `count_o` at 0, where it stays.
- R8: With `reload_on` high, a step from 1 loads the start value into `count_o`.
- R9: `expire_o` is high for exactly the cycle after each edge at which a step from 1 happened. It is low at all other times.
- R10: With `reload_on` high and a start value of 0, the count stays at 0 and `expire_o` stays low.
- R11: A start-value write while the timer is running changes neither the current count nor the step sequence. It takes effect only at the next load or reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 13.56 MHz carrier-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Start-value write strobe |
| cfg_wr_data | input | 32 | Write data; only bits 19:0 are kept |
| start_rd_o | output | 32 | Start-value readback; upper bits are zero |
| run_en | input | 1 | Run control; a rising level loads the counter |
| prescale_on | input | 1 | 0: step every clock; 1: step on divider ticks |
| prescale_code | input | 3 | Division ratio code, ratio = 2^(code+1) |
| reload_on | input | 1 | 0: single shot; 1: repeating |
| count_o | output | 20 | Current count |
| expire_o | output | 1 | One-cycle expiry strobe |

## Verification
Three events can land on the same edge:
- a divider tick and the step from 1 to expiry;
- the load on the rising edge of `run_en` and a start-value write;
- in repeating mode, an expiry and the reload of a start value that a write has just changed.

The bench provokes each of these. It uses short start values such as 1 and 2 under every division code, writes the start value in the same cycle that `run_en` rises, and rewrites the value just before the count reaches 1. A behavioural model, which counts elapsed cycles with integers, predicts the count, the strobe and the readback. These are compared after every edge, so any mistake in which of two simultaneous events wins shows up as a mismatch on that exact cycle.

// File: rtl/ctmr_pkg.sv
// Package: shared sizing constants for the carrier countdown timer.
// Assumes: every other file of the timer imports it.
package ctmr_pkg;
    localparam int CTMR_CNT_W = 20;  // counter and start-value width
    localparam int CTMR_BUS_W = 32;  // register write/read width
    localparam int CTMR_SEL_W = 3;   // divider code width
endpackage

// File: rtl/ctmr_start_reg.sv
// Module: start-value register. It keeps the low CNT_W bits of a bus write
// and returns them zero-extended to BUS_W.
// Assumes: BUS_W >= CNT_W, and the writer and reader are in the clk domain.
module ctmr_start_reg #(
    parameter int CNT_W = ctmr_pkg::CTMR_CNT_W,
    parameter int BUS_W = ctmr_pkg::CTMR_BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wr_data,
    output logic [CNT_W-1:0] start_val,
    output logic [BUS_W-1:0] rd_data
);
    localparam int PAD_W = BUS_W - CNT_W;

    logic [CNT_W-1:0] val_q;

    // Capture the low field on a write; the reserved upper bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            val_q <= '0;
        else if (wr_en)
            val_q <= wr_data[CNT_W-1:0];
    end

    assign start_val = val_q;
    assign rd_data   = {{PAD_W{1'b0}}, val_q};
endmodule

// File: rtl/ctmr_divider.sv
// Module: free-running power-of-two divider. It emits a one-cycle tick
// enable, either every clock (bypass) or once per 2^(code+1) clocks.
// Assumes: run_en low holds the divider at phase 0, so a fresh run
// starts from a known phase. It produces an enable only, never a clock.
module ctmr_divider #(
    parameter int SEL_W = ctmr_pkg::CTMR_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             prescale_on,
    input  logic [SEL_W-1:0] code,
    output logic             tick
);
    localparam int NCODE = 2 ** SEL_W;
    localparam int DIV_W = NCODE;          // wide enough for ratio 2^NCODE

    logic [DIV_W-1:0] phase_q;
    logic [NCODE-1:0] wrap_vec;

    // Advance the phase while running; park it at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    // One wrap detector per code: ratio 2^(i+1) wraps when the low i+1 bits are all ones.
    for (genvar i = 0; i < NCODE; i++) begin : g_wrap
        assign wrap_vec[i] = &phase_q[i:0];
    end

    // Choose the tick source: every clock in bypass, else the selected wrap.
    always_comb begin
        if (!run_en)
            tick = 1'b0;
        else if (!prescale_on)
            tick = 1'b1;
        else
            tick = wrap_vec[code];
    end

    // Idle divider makes no tick (R6).
    p_idle_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!run_en) |-> (phase_q == '0));
endmodule

// File: rtl/ctmr_down_counter.sv
// Module: the down-counter. It loads on a rising run level, steps on tick,
// and at the step from 1 either parks at zero or reloads, raising a
// one-cycle expiry strobe.
// Assumes: tick is a single-cycle enable in the clk domain.
module ctmr_down_counter #(
    parameter int CNT_W = ctmr_pkg::CTMR_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             tick,
    input  logic             reload_on,
    input  logic [CNT_W-1:0] start_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    logic             exp_q;
    logic             start;
    logic             last_step;

    assign start     = run_en && !run_q;
    assign last_step = run_en && !start && tick && (cnt_q == ONE);

    // Remember the previous run level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 1'b0;
        else
            run_q <= run_en;
    end

    // Count update: load on start, step on tick, terminate at one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= start_val;
        else if (last_step)
            cnt_q <= reload_on ? start_val : '0;
        else if (run_en && tick && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    // Expiry strobe, registered so that it lines up with the new count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            exp_q <= 1'b0;
        else
            exp_q <= last_step;
    end

    assign count  = cnt_q;
    assign expire = exp_q;

    // Rising run loads the start value (R3).
    p_start_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(start) |-> (cnt_q == $past(start_val)));

    // Ordinary step removes exactly one (R4).
    p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && run_en && run_q && tick && (cnt_q > ONE)) |-> (cnt_q == $past(cnt_q) - ONE));

    // Idle timer holds its count (R6).
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!run_en) |-> $stable(cnt_q));

    // Single-shot expiry lands on zero (R7).
    p_oneshot_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exp_q && $past(!reload_on) |-> (cnt_q == '0));
endmodule

// File: rtl/carrier_countdown_timer.sv
// Module: top of the prescaled reloadable countdown timer. It joins the
// start-value register, the tick divider and the down-counter.
// Assumes: a single clk domain (13.56 MHz carrier) and synchronous active-low reset.
module carrier_countdown_timer #(
    parameter int CNT_W = ctmr_pkg::CTMR_CNT_W,
    parameter int BUS_W = ctmr_pkg::CTMR_BUS_W,
    parameter int SEL_W = ctmr_pkg::CTMR_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [BUS_W-1:0] cfg_wr_data,
    output logic [BUS_W-1:0] start_rd_o,
    input  logic             run_en,
    input  logic             prescale_on,
    input  logic [SEL_W-1:0] prescale_code,
    input  logic             reload_on,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    logic [CNT_W-1:0] start_val;
    logic             tick;

    ctmr_start_reg #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_data   (cfg_wr_data),
        .start_val (start_val),
        .rd_data   (start_rd_o)
    );

    ctmr_divider #(.SEL_W(SEL_W)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .prescale_on (prescale_on),
        .code        (prescale_code),
        .tick        (tick)
    );

    ctmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .tick      (tick),
        .reload_on (reload_on),
        .start_val (start_val),
        .count     (count_o),
        .expire    (expire_o)
    );
endmodule

// File: tb/carrier_countdown_timer_tb_top.sv
// Bench: a behavioural cycle model, compared with the design after every edge.
module carrier_countdown_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] start_rd_o;
    logic        run_en = 1'b0;
    logic        prescale_on = 1'b0;
    logic [2:0]  prescale_code = '0;
    logic        reload_on = 1'b0;
    logic [19:0] count_o;
    logic        expire_o;

    carrier_countdown_timer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .start_rd_o(start_rd_o), .run_en(run_en), .prescale_on(prescale_on),
        .prescale_code(prescale_code), .reload_on(reload_on),
        .count_o(count_o), .expire_o(expire_o)
    );

    always #2.5 clk = ~clk;   // 200 MHz

    int    n_vec = 0;
    int    n_bad = 0;
    string tag = "R2";
    int    m_cnt = 0, m_start = 0, m_elapsed = 0, m_exp = 0;
    bit    m_run_prev = 0;
    int    exp_seen = 0;

    // Model of one edge, computed from the inputs that were present at that edge.
    task automatic model_edge();
        int ratio;
        bit stepped;
        if (!rst_n) begin
            m_cnt = 0; m_start = 0; m_exp = 0; m_elapsed = 0; m_run_prev = 0;
            return;
        end
        m_exp = 0;
        ratio = 2 << prescale_code;
        if (run_en && !m_run_prev) begin
            m_cnt = m_start; m_elapsed = 1;
        end else if (run_en) begin
            stepped = !prescale_on || ((m_elapsed % ratio) == ratio - 1);
            m_elapsed++;
            if (stepped && m_cnt == 1) begin
                m_exp = 1;
                m_cnt = reload_on ? m_start : 0;
            end else if (stepped && m_cnt != 0) begin
                m_cnt--;
            end
        end else begin
            m_elapsed = 0;
        end
        if (cfg_wr_en) m_start = cfg_wr_data[19:0];
        m_run_prev = run_en;
    endtask

    // Advance one clock and compare all outputs away from the active edge.
    task automatic cyc();
        @(negedge clk);
        model_edge();
        n_vec++;
        if (expire_o) exp_seen++;
        if (count_o !== 20'(m_cnt) || expire_o !== m_exp[0] || start_rd_o !== 32'(m_start)) begin
            n_bad++;
            $display("FAIL %s t=%0t count=%0d/%0d expire=%0b/%0b rd=%h/%h (actual/expected)",
                     tag, $time, count_o, m_cnt, expire_o, m_exp[0], start_rd_o, m_start);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input logic [31:0] d);
        cfg_wr_en = 1'b1; cfg_wr_data = d; cyc(); cfg_wr_en = 1'b0;
    endtask

    // Watchdog: a hang counts as a miscompare and still reaches the summary line.
    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        tag = "R2"; cycles(3);                     // reset state
        rst_n = 1'b1; cycles(2);

        tag = "R1"; wr(32'hABC1_2345); cycles(2);  // upper bits dropped, readback
        wr(32'h0000_0007);

        tag = "R4"; run_en = 1; cycles(4);         // R3 load, then bypass stepping
        tag = "R7"; cycles(8);                     // single shot parks at zero
        run_en = 0; cycles(2);

        tag = "R8"; reload_on = 1; wr(32'd3);      // repeating, short period
        run_en = 1; exp_seen = 0; cycles(13);
        tag = "R9"; cycles(1);
        if (exp_seen < 3) begin n_bad++; $display("FAIL R9 pulses=%0d expected>=3", exp_seen); end
        n_vec++;
        wr(32'd1); cycles(6);                      // R9 back-to-back strobes at start value 1
        run_en = 0; cycles(3);

        tag = "R6"; wr(32'd9); run_en = 1; cycles(3);
        run_en = 0; cycles(5); run_en = 1; cycles(4); run_en = 0; cycles(2);

        tag = "R5"; prescale_on = 1;               // every division code, start values 2 and 1
        for (int c = 0; c < 8; c++) begin
            prescale_code = 3'(c);
            wr(32'd2); run_en = 1; cycles((2 << c) * 4 + 3);
            run_en = 0; cycles(1);
            reload_on = 0; wr(32'd1); run_en = 1; cycles((2 << c) * 2 + 2);
            run_en = 0; reload_on = 1; cycles(1);
        end
        prescale_code = 3'd2; wr(32'd4); run_en = 1; cycles(11);
        prescale_code = 3'd0; cycles(9);           // code changed mid-run
        run_en = 0; prescale_on = 0; cycles(2);

        tag = "R10"; wr(32'd0); exp_seen = 0; run_en = 1; cycles(20);
        if (exp_seen != 0) begin n_bad++; $display("FAIL R10 pulses=%0d expected=0", exp_seen); end
        n_vec++;
        run_en = 0; cycles(1);

        tag = "R11"; wr(32'd5); run_en = 1; cycles(2);
        wr(32'd12); cycles(6);                     // new value appears only at reload
        run_en = 0; cycles(1);
        tag = "R3"; cfg_wr_en = 1; cfg_wr_data = 32'd30; run_en = 1; cyc();
        cfg_wr_en = 0; cycles(5);                  // load used 12, not 30
        run_en = 0; cycles(2);

        tag = "R2"; run_en = 1; cycles(3); rst_n = 0; cycles(2); run_en = 0; rst_n = 1; cycles(2);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule